// File: doc/BRIEF.md
# Exclusive Private Victim Cache (Tag Model)

This block tracks the tags of a per-core second-level cache that is kept exclusive with the first level. Lines come into it only when the first level throws them out. Lines that arrive from memory go straight to the first level and never allocate here. When the first level misses, it looks up this cache. On a hit, the line leaves this cache and moves up to the first level, taking its modified status with it. On a miss, the response tells the requester to go on to the shared level.

Each set holds `WAYS` lines. A tree pseudo-LRU picks the replacement way when a first-level victim arrives at a full set. The displaced line then leaves on the outgoing victim port toward the shared level, together with its dirty flag. Lines are 64 bytes and the model holds only tags, valid bits and dirty bits. Every output is registered and belongs to the request presented on the cycle before.

Top module: `evc_victim_cache`

## Requirements
- R1: Lines are 64 bytes. Address bits [5:0] play no part in matching, and `rsp_addr_o` and `evict_addr_o` always carry them as zero.
- R2: A lookup that misses gives `rsp_valid_o`=1 and `rsp_hit_o`=0 on the next cycle and allocates nothing, so a repeat lookup of the same line also misses. A fill from memory never reaches this cache.
- R3: A lookup that hits gives `rsp_valid_o`=1 and `rsp_hit_o`=1 on the next cycle and invalidates the entry, so a repeat lookup of the same line misses.
- R4: An insert into a set with at least one invalid way takes the lowest-indexed invalid way and raises no eviction.
- R5: An insert into a set whose ways are all valid replaces one way. On the next cycle it raises `evict_valid_o` with the displaced line's address and dirty flag.
- R6: Each set keeps a tree of WAYS-1 bits, with node k's children at 2k+1 and 2k+2. The replacement walk goes to the lower half on a 0 and to the upper half on a 1. Every insert sets each node on the path to point away from the way that was written.
- R7: The dirty flag given with an insert comes back as `rsp_dirty_o` when that line later hits.
- R8: A lookup and an insert of the same line in the same cycle resolve in favour of the insert. The response is a hit carrying the insert's dirty flag, nothing is allocated, and no eviction is raised.
- R9: A lookup that hits in the same set as a same-cycle insert into a full set frees its way. The insert takes that way and no eviction is raised.
- R10: An insert of a line already present ORs the dirty flags into the existing entry. It creates no second copy, raises no eviction and updates the tree for that way.
- R11: After reset, every entry is invalid, every tree bit is 0, and `rsp_valid_o` and `evict_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lk_valid_i | input | 1 | First-level miss lookup request |
| lk_addr_i | input | ADDR_W | Lookup byte address |
| ins_valid_i | input | 1 | First-level victim insert request |
| ins_addr_i | input | ADDR_W | Inserted line byte address |
| ins_dirty_i | input | 1 | Inserted line is modified |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | 1: line moved up; 0: go to shared level |
| rsp_addr_o | output | ADDR_W | Line address of the response |
| rsp_dirty_o | output | 1 | Modified status of the moved-up line |
| evict_valid_o | output | 1 | Victim sent to the shared level |
| evict_addr_o | output | ADDR_W | Line address of the victim |
| evict_dirty_o | output | 1 | Victim is modified |

## Verification
The bench runs a small cache (8 sets, 4 ways) against a reference model in the bench. It goes after three corner cases: same-cycle lookup and insert of one line, a lookup hit that frees a way in a full set while an insert arrives, and re-insertion of a line that is already present. Getting these wrong shows up as a stray victim on the outgoing port, a duplicate entry, or a lost dirty flag. A long pseudo-random sweep over a few tags in two crowded sets exercises the replacement tree. A wrong tree walk or update names a different victim, and a cache that allocated on misses or kept hit lines would turn later misses into hits.

// File: rtl/vc_pkg.sv
package vc_pkg;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned OFF_W      = $clog2(LINE_BYTES);

  typedef enum logic [1:0] {
    INS_NONE,
    INS_MERGE,
    INS_FREE,
    INS_REPLACE
  } ins_act_e;
endpackage

// File: rtl/vc_way_match.sv
module vc_way_match #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
  input  logic [TAG_W-1:0]           tag_i,
  output logic [WAYS-1:0]            hit_vec_o,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  assign hit_o = |hit_vec_o;

  always_comb begin
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec_o[w]) way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/vc_plru_tree.sv
module vc_plru_tree #(
  parameter int unsigned WAYS = 4,
  localparam int unsigned WAY_W = $clog2(WAYS),
  localparam int unsigned NODES = WAYS - 1
) (
  input  logic [NODES-1:0] state_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAY_W-1:0] victim_o,
  output logic [NODES-1:0] state_o
);
  // walk: 0 -> lower half, 1 -> upper half
  always_comb begin
    int unsigned node;
    node     = 0;
    victim_o = '0;
    for (int l = 0; l < WAY_W; l++) begin
      victim_o = {victim_o[WAY_W-2:0], state_i[node]};
      node     = 2 * node + 1 + int'(state_i[node]);
    end
  end

  // touch: every node on the path points away from the written way
  always_comb begin
    int unsigned node;
    logic        b;
    node    = 0;
    state_o = state_i;
    for (int l = 0; l < WAY_W; l++) begin
      b             = touch_way_i[WAY_W-1-l];
      state_o[node] = ~b;
      node          = 2 * node + 1 + int'(b);
    end
  end
endmodule

// File: rtl/evc_victim_cache.sv
module evc_victim_cache
  import vc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SETS   = 8,
  parameter int unsigned WAYS   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic              ins_valid_i,
  input  logic [ADDR_W-1:0] ins_addr_i,
  input  logic              ins_dirty_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic              rsp_dirty_o,
  output logic              evict_valid_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic              evict_dirty_o
);
  localparam int unsigned IDX_W = $clog2(SETS);
  localparam int unsigned WAY_W = $clog2(WAYS);
  localparam int unsigned TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int unsigned NODES = WAYS - 1;
  localparam int unsigned OCC_W = $clog2(SETS * WAYS + 1);

  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [NODES-1:0]           plru_q  [SETS];

  logic [IDX_W-1:0] lk_idx, ins_idx;
  logic [TAG_W-1:0] lk_tag, ins_tag;
  assign lk_idx  = lk_addr_i[OFF_W +: IDX_W];
  assign ins_idx = ins_addr_i[OFF_W +: IDX_W];
  assign lk_tag  = lk_addr_i[ADDR_W-1 -: TAG_W];
  assign ins_tag = ins_addr_i[ADDR_W-1 -: TAG_W];

  logic unused_offsets;
  assign unused_offsets = ^{lk_addr_i[OFF_W-1:0], ins_addr_i[OFF_W-1:0]};

  logic [WAYS-1:0]  lk_hit_vec, ins_hit_vec;
  logic             lk_hit, ins_hit;
  logic [WAY_W-1:0] lk_way, ins_hit_way;

  vc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid_i(valid_q[lk_idx]), .tags_i(tag_q[lk_idx]), .tag_i(lk_tag),
    .hit_vec_o(lk_hit_vec), .hit_o(lk_hit), .way_o(lk_way)
  );

  vc_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ins_match (
    .valid_i(valid_q[ins_idx]), .tags_i(tag_q[ins_idx]), .tag_i(ins_tag),
    .hit_vec_o(ins_hit_vec), .hit_o(ins_hit), .way_o(ins_hit_way)
  );

  // same-line lookup + insert: line goes straight up, nothing stored
  logic bypass, lk_take, ins_go, same_set;
  assign bypass   = lk_valid_i && ins_valid_i &&
                    (lk_addr_i[ADDR_W-1:OFF_W] == ins_addr_i[ADDR_W-1:OFF_W]);
  assign lk_take  = lk_valid_i && lk_hit && !bypass;
  assign ins_go   = ins_valid_i && !bypass;
  assign same_set = lk_take && (lk_idx == ins_idx);

  logic [WAYS-1:0]  free_vec;
  logic             free_any;
  logic [WAY_W-1:0] free_way;
  assign free_vec = ~valid_q[ins_idx] | (same_set ? lk_hit_vec : '0);
  assign free_any = |free_vec;

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free_vec[w]) free_way = WAY_W'(w);
    end
  end

  ins_act_e         ins_act;
  logic [WAY_W-1:0] ins_way, plru_victim;
  logic [NODES-1:0] plru_next;

  always_comb begin
    if (!ins_go)       ins_act = INS_NONE;
    else if (ins_hit)  ins_act = INS_MERGE;
    else if (free_any) ins_act = INS_FREE;
    else               ins_act = INS_REPLACE;
  end

  always_comb begin
    unique case (ins_act)
      INS_MERGE: ins_way = ins_hit_way;
      INS_FREE:  ins_way = free_way;
      default:   ins_way = plru_victim;
    endcase
  end

  vc_plru_tree #(.WAYS(WAYS)) u_plru (
    .state_i(plru_q[ins_idx]), .touch_way_i(ins_way),
    .victim_o(plru_victim), .state_o(plru_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        tag_q[s]   <= '0;
        plru_q[s]  <= '0;
      end
      rsp_valid_o   <= 1'b0;
      rsp_hit_o     <= 1'b0;
      rsp_addr_o    <= '0;
      rsp_dirty_o   <= 1'b0;
      evict_valid_o <= 1'b0;
      evict_addr_o  <= '0;
      evict_dirty_o <= 1'b0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      rsp_hit_o   <= lk_valid_i && (bypass || lk_hit);
      rsp_addr_o  <= {lk_addr_i[ADDR_W-1:OFF_W], OFF_W'(0)};
      rsp_dirty_o <= bypass ? ins_dirty_i : (lk_take && dirty_q[lk_idx][lk_way]);

      evict_valid_o <= (ins_act == INS_REPLACE);
      evict_addr_o  <= {tag_q[ins_idx][ins_way], ins_idx, OFF_W'(0)};
      evict_dirty_o <= dirty_q[ins_idx][ins_way];

      if (lk_take) valid_q[lk_idx][lk_way] <= 1'b0;
      if (ins_go) begin
        valid_q[ins_idx][ins_way] <= 1'b1;
        tag_q[ins_idx][ins_way]   <= ins_tag;
        dirty_q[ins_idx][ins_way] <= ins_dirty_i ||
                                     (ins_act == INS_MERGE && dirty_q[ins_idx][ins_way]);
        plru_q[ins_idx]           <= plru_next;
      end
    end
  end

  logic [OCC_W-1:0] occ;
  always_comb begin
    occ = '0;
    for (int s = 0; s < SETS; s++) occ = occ + OCC_W'($countones(valid_q[s]));
  end

  p_miss_no_alloc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !lk_hit && !ins_valid_i |=> occ == $past(occ));

  p_hit_rsp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && lk_hit |=> rsp_valid_o && rsp_hit_o);

  p_hit_drains_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_take && !ins_valid_i |=> occ == $past(occ) - OCC_W'(1));

  p_free_no_evict_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && !bypass && !ins_hit && !(&valid_q[ins_idx]) |=> !evict_valid_o);

  p_full_evicts_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && !bypass && !ins_hit && (&valid_q[ins_idx]) && !same_set
    |=> evict_valid_o);

  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass |=> rsp_hit_o && (rsp_dirty_o == $past(ins_dirty_i)) && !evict_valid_o);

  p_vacated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_valid_i && same_set |=> !evict_valid_o);

  p_unique_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ins_hit_vec) && $onehot0(lk_hit_vec));
endmodule

// File: tb/evc_victim_cache_tb_top.sv
module evc_victim_cache_tb_top;
  localparam int ADDR_W = 32;
  localparam int SETS   = 8;
  localparam int WAYS   = 4;
  localparam int TAG_W  = ADDR_W - 6 - 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic              lk_valid_i = 1'b0, ins_valid_i = 1'b0, ins_dirty_i = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0, ins_addr_i = '0;
  logic              rsp_valid_o, rsp_hit_o, rsp_dirty_o;
  logic              evict_valid_o, evict_dirty_o;
  logic [ADDR_W-1:0] rsp_addr_o, evict_addr_o;

  evc_victim_cache #(.ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_addr_i(lk_addr_i),
    .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i), .ins_dirty_i(ins_dirty_i),
    .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o), .rsp_addr_o(rsp_addr_o),
    .rsp_dirty_o(rsp_dirty_o), .evict_valid_o(evict_valid_o),
    .evict_addr_o(evict_addr_o), .evict_dirty_o(evict_dirty_o)
  );

  int n_run = 0, n_fail = 0;

  // reference model
  bit             m_v [SETS][WAYS];
  bit             m_d [SETS][WAYS];
  bit [TAG_W-1:0] m_t [SETS][WAYS];
  bit [2:0]       m_p [SETS];
  bit              e_rv, e_rh, e_rd, e_ev, e_ed;
  bit [ADDR_W-1:0] e_ra, e_ea;

  function automatic int plru_victim(bit [2:0] p);
    return (p[0] == 1'b0) ? (p[1] ? 1 : 0) : (p[2] ? 3 : 2);
  endfunction

  function automatic bit [2:0] plru_touch(bit [2:0] p, int w);
    bit [2:0] q = p;
    if (w < 2) begin q[0] = 1'b1; q[1] = (w == 0); end
    else       begin q[0] = 1'b0; q[2] = (w == 2); end
    return q;
  endfunction

  function automatic bit [ADDR_W-1:0] mk(int tag, int set, int off);
    return (ADDR_W'(tag) << 9) | (ADDR_W'(set) << 6) | ADDR_W'(off & 63);
  endfunction

  task automatic model(bit lv, bit [ADDR_W-1:0] la, bit iv, bit [ADDR_W-1:0] ia, bit id);
    int ls = int'(la[8:6]), is = int'(ia[8:6]);
    bit [TAG_W-1:0] lt = la[ADDR_W-1:9], it = ia[ADDR_W-1:9];
    bit byp = lv && iv && (la[ADDR_W-1:6] == ia[ADDR_W-1:6]);
    int lw = -1, pw = -1, fw = -1, w;
    e_rv = lv; e_rh = 0; e_rd = 0; e_ev = 0; e_ed = 0; e_ea = '0;
    e_ra = {la[ADDR_W-1:6], 6'd0};
    if (lv && !byp)
      for (int k = 0; k < WAYS; k++) if (m_v[ls][k] && m_t[ls][k] == lt) lw = k;
    if (byp) begin e_rh = 1; e_rd = id; end
    else if (lw >= 0) begin e_rh = 1; e_rd = m_d[ls][lw]; end
    if (iv && !byp) begin
      for (int k = 0; k < WAYS; k++) if (m_v[is][k] && m_t[is][k] == it) pw = k;
      for (int k = WAYS - 1; k >= 0; k--)
        if (!m_v[is][k] || (lw == k && ls == is)) fw = k;
    end
    if (lw >= 0) m_v[ls][lw] = 0;
    if (iv && !byp) begin
      if (pw >= 0) begin w = pw; m_d[is][w] = m_d[is][w] | id; end
      else begin
        if (fw >= 0) w = fw;
        else begin
          w = plru_victim(m_p[is]);
          e_ev = 1; e_ed = m_d[is][w];
          e_ea = mk(int'(m_t[is][w]), is, 0);
        end
        m_d[is][w] = id;
      end
      m_v[is][w] = 1; m_t[is][w] = it;
      m_p[is] = plru_touch(m_p[is], w);
    end
  endtask

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit lv, bit [ADDR_W-1:0] la, bit iv,
                      bit [ADDR_W-1:0] ia, bit id);
    model(lv, la, iv, ia, id);
    lk_valid_i = lv; lk_addr_i = la; ins_valid_i = iv; ins_addr_i = ia; ins_dirty_i = id;
    @(posedge clk_i);
    @(negedge clk_i);
    lk_valid_i = 0; ins_valid_i = 0;
    chk(req, "rsp_valid", 64'(rsp_valid_o), 64'(e_rv));
    if (e_rv) begin
      chk(req, "rsp_hit", 64'(rsp_hit_o), 64'(e_rh));
      chk(req, "rsp_addr", 64'(rsp_addr_o), 64'(e_ra));
      if (e_rh) chk(req, "rsp_dirty", 64'(rsp_dirty_o), 64'(e_rd));
    end
    chk(req, "evict_valid", 64'(evict_valid_o), 64'(e_ev));
    if (e_ev) begin
      chk(req, "evict_addr", 64'(evict_addr_o), 64'(e_ea));
      chk(req, "evict_dirty", 64'(evict_dirty_o), 64'(e_ed));
    end
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    bit [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk_i);
    // R11: reset state
    chk("R11", "rsp_valid", 64'(rsp_valid_o), 0);
    chk("R11", "evict_valid", 64'(evict_valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: miss and no allocation
    step("R2", 1, mk(5, 0, 0), 0, '0, 0);
    step("R2", 1, mk(5, 0, 0), 0, '0, 0);
    // R4: fill set 0 through free ways
    step("R4", 0, '0, 1, mk(1, 0, 0), 1);
    step("R4", 0, '0, 1, mk(2, 0, 0), 0);
    step("R4", 0, '0, 1, mk(3, 0, 0), 1);
    step("R4", 0, '0, 1, mk(4, 0, 0), 0);
    // R3 and R7: hit moves the line up with its dirty flag, then misses
    step("R7", 1, mk(3, 0, 0), 0, '0, 0);
    chk("R7", "rsp_dirty direct", 64'(rsp_dirty_o), 1);
    step("R3", 1, mk(3, 0, 0), 0, '0, 0);
    chk("R3", "rsp_hit after move-up", 64'(rsp_hit_o), 0);
    step("R4", 0, '0, 1, mk(3, 0, 0), 0);
    // R9: hit in the full set frees a way for a same-cycle insert
    step("R9", 1, mk(2, 0, 0), 1, mk(6, 0, 0), 1);
    chk("R9", "evict_valid direct", 64'(evict_valid_o), 0);
    // R5 and R6: full set replacement by tree
    step("R5", 0, '0, 1, mk(7, 0, 0), 0);
    chk("R5", "evict_valid direct", 64'(evict_valid_o), 1);
    step("R6", 0, '0, 1, mk(8, 0, 0), 1);
    step("R6", 0, '0, 1, mk(9, 0, 0), 0);
    // R8: same-line lookup and insert
    step("R8", 1, mk(10, 1, 0), 1, mk(10, 1, 5), 1);
    step("R8", 1, mk(10, 1, 0), 0, '0, 0);
    // R10: re-insert merges dirty
    step("R10", 0, '0, 1, mk(11, 2, 0), 1);
    step("R10", 0, '0, 1, mk(11, 2, 0), 0);
    step("R10", 1, mk(11, 2, 0), 0, '0, 0);
    chk("R10", "merged dirty", 64'(rsp_dirty_o), 1);
    // R1: offset bits ignored
    step("R1", 0, '0, 1, mk(12, 3, 17), 0);
    step("R1", 1, mk(12, 3, 63), 0, '0, 0);
    chk("R1", "rsp_addr offset", 64'(rsp_addr_o[5:0]), 0);
    // sweep: few tags, two crowded sets
    for (int i = 0; i < 6000; i++) begin
      bit [ADDR_W-1:0] la, ia;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      la = mk(int'(lf[4:2]), int'(lf[5]), int'(lf[15:10]));
      ia = lf[8] ? la : mk(int'(lf[11:9]), int'(lf[12]), int'(lf[7:2]));
      step("R6", lf[0], la, lf[1] | lf[14], ia, lf[13]);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule